// File: doc/BRIEF.md
# Global Interrupt Pending Register

This block is the byte-wide pending register for three global interrupt sources of a CAN controller's host interface. The three sources are a wake-up from the clock-stopped sleep mode, a rejected (invalid) register write, and an access to an address that holds no memory. An event sets its pending bit only while that source's enable input is high. The bit then stays set until software writes a 1 to its position. Turning the enable off does not clear a bit that is already pending.

Each source has one interrupt request output. It pulses for a single clock when the pending bit goes from 0 to 1. Further events of the same kind that arrive while the bit is still set are merged into that one request. Software can therefore clear the bit early in its service routine so that the next event raises a fresh request.

Each source runs its own two-state machine, built by a generate loop. The states are `ST_IDLE` (not pending) and `ST_PEND` (pending), with these transitions:

- `T_SET`: `ST_IDLE` to `ST_PEND`, taken on an enabled event. It also raises the request pulse.
- `T_CLR`: `ST_PEND` to `ST_IDLE`, taken on a write-1 with no enabled event in the same cycle.
- `T_HOLD`: the self-loop on either state for every other case. That includes an enabled event while the bit is already `ST_PEND`, which produces no pulse.

Top module: `gip_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and every `irq` bit is 0.
- R2: An event with its enable high sets the bit for that source on the next clock edge. The bit positions are: `evt[0]` sets bit 1 (unavailable-address access), `evt[1]` sets bit 2 (invalid write), and `evt[2]` sets bit 3 (wake-up).
- R3: An event whose enable is low leaves the register unchanged and raises no `irq`.
- R4: A write with `wr_en` high clears every pending bit whose `wr_data` position holds 1. Positions holding 0 keep their value.
- R5: Dropping an enable while its bit is pending leaves the bit set.
- R6: `irq[i]` is high for exactly one clock. That clock is the first cycle in which the matching pending bit reads 1 after having read 0.
- R7: An enabled event while the bit is already pending keeps the bit set and raises no `irq`.
- R8: When an enabled event and a write-1 clear reach the same bit in the same cycle, the bit reads 1 afterwards. It gives a pulse only if it was 0 before.
- R9: Bits 7 to 4 and bit 0 always read 0, and writes to those positions have no effect.
- R10: The sources are independent. A clear or an event on one bit leaves the other bits and their `irq` outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe for the register |
| wr_data | input | 8 | Write data; a 1 clears the pending bit at that position |
| rd_data | output | 8 | Current register value |
| evt | input | 3 | Per-source event strobes (0: address, 1: invalid write, 2: wake-up) |
| ena | input | 3 | Per-source enables |
| irq | output | 3 | Per-source one-clock interrupt requests |

## Verification
The bench builds the block with its default parameters: an 8-bit register, three sources and the first used bit at position 1. This layout places unused positions both below and above the used field, so the bench can check that writes to bit 0 and to bits 7 to 4 are ignored. Because there are three independent machines, the bench can fire events on one source while it clears another in the same cycle. It also covers the simultaneous set-and-clear case, both when the bit starts clear and when it starts pending.

// File: rtl/gip_pkg.sv
package gip_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } gip_state_e;
endpackage

// File: rtl/gip_src_fsm.sv
module gip_src_fsm
    import gip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ena_i,
    input  logic clr_i,
    output logic pend_o,
    output logic irq_o
);
    gip_state_e state_q, state_d;
    logic       set_hit;
    logic       irq_d;

    assign set_hit = evt_i & ena_i;

    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (set_hit) begin
                    state_d = ST_PEND;   // T_SET
                    irq_d   = 1'b1;
                end
            end
            ST_PEND: begin
                if (!set_hit && clr_i) begin
                    state_d = ST_IDLE;   // T_CLR
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_d;
    end

    assign pend_o = (state_q == ST_PEND);
endmodule

// File: rtl/gip_bus_port.sv
module gip_bus_port #(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 3,
    parameter int SRC_LSB = 1
) (
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] clr,
    output logic [DATA_W-1:0]  rd_data
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i >= SRC_LSB && i < SRC_LSB + NUM_SRC) begin : g_used
            assign rd_data[i]         = pend[i-SRC_LSB];
            assign clr[i-SRC_LSB]     = wr_en & wr_data[i];
        end else begin : g_unused
            assign rd_data[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gip_reg.sv
module gip_reg #(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 3,
    parameter int SRC_LSB = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] ena,
    output logic [NUM_SRC-1:0] irq
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;

    gip_bus_port #(
        .DATA_W (DATA_W),
        .NUM_SRC(NUM_SRC),
        .SRC_LSB(SRC_LSB)
    ) u_bus (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .pend   (pend),
        .clr    (clr),
        .rd_data(rd_data)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        gip_src_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt[s]),
            .ena_i (ena[s]),
            .clr_i (clr[s]),
            .pend_o(pend[s]),
            .irq_o (irq[s])
        );
    end
endmodule

// File: rtl/gip_reg_chk.sv
module gip_reg_chk #(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 3,
    parameter int SRC_LSB = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] ena,
    input logic [NUM_SRC-1:0] irq
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'(((1 << NUM_SRC) - 1) << SRC_LSB);

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED_MASK) == '0); // R9

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        localparam int B = SRC_LSB + i;

        AST_IRQ_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (rd_data[B] && !$past(rd_data[B]))); // R6
        AST_RISE_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[B] && !$past(rd_data[B])) |-> irq[i]); // R6
        AST_SET_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[B] && !$past(rd_data[B])) |-> $past(evt[i] && ena[i])); // R3
        AST_ENABLED_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && ena[i]) |=> rd_data[B]); // R8
        AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[B] && !(evt[i] && ena[i])) |=> !rd_data[B]); // R4
        AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(evt[i] && ena[i]) && !(wr_en && wr_data[B])) |=> $stable(rd_data[B])); // R5
    end
endmodule

bind gip_reg gip_reg_chk #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC),
    .SRC_LSB(SRC_LSB)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .evt    (evt),
    .ena    (ena),
    .irq    (irq)
);

// File: tb/gip_reg_tb.sv
module gip_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] evt = '0;
    logic [2:0] ena = '0;
    logic [2:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gip_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .evt(evt), .ena(ena), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] exp_rd,
                         input logic [2:0] exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: rd=%02h irq=%03b expected rd=%02h irq=%03b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    // drive at negedge, advance one rising edge, sample 1 ns later
    task automatic cyc(input logic w, input logic [7:0] wd,
                       input logic [2:0] e, input logic [2:0] en);
        @(negedge clk);
        wr_en = w; wr_data = wd; evt = e; ena = en;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_data = '0; evt = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 8'h00, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_set_each;
        cyc(0, 0, 3'b001, 3'b111); check("R2 addr->bit1", 8'h02, 3'b001);
        cyc(0, 0, 3'b000, 3'b111); check("R6 pulse ends", 8'h02, 3'b000);
        cyc(0, 0, 3'b010, 3'b111); check("R2 inval->bit2", 8'h06, 3'b010);
        cyc(0, 0, 3'b100, 3'b111); check("R2 wake->bit3", 8'h0E, 3'b100);
        cyc(0, 0, 3'b000, 3'b111); check("R6 no lingering", 8'h0E, 3'b000);
        cyc(1, 8'h0E, 3'b000, 3'b111); check("R4 clear all", 8'h00, 3'b000);
    endtask

    task automatic t_disabled;
        cyc(0, 0, 3'b111, 3'b000); check("R3 no enable", 8'h00, 3'b000);
        cyc(0, 0, 3'b111, 3'b010); check("R3 partial enable", 8'h04, 3'b010);
        cyc(1, 8'h04, 3'b000, 3'b000); check("R4 clear bit2", 8'h00, 3'b000);
    endtask

    task automatic t_w1c;
        cyc(0, 0, 3'b111, 3'b111); check("R2 all set", 8'h0E, 3'b111);
        cyc(1, 8'h00, 3'b000, 3'b111); check("R4 write zero", 8'h0E, 3'b000);
        cyc(1, 8'h04, 3'b000, 3'b111); check("R4 clear only bit2", 8'h0A, 3'b000);
        cyc(1, 8'hF1, 3'b000, 3'b111); check("R9 unused write", 8'h0A, 3'b000);
        cyc(1, 8'h0A, 3'b000, 3'b111); check("R4 clear rest", 8'h00, 3'b000);
    endtask

    task automatic t_enable_drop;
        cyc(0, 0, 3'b100, 3'b100); check("R2 wake set", 8'h08, 3'b100);
        cyc(0, 0, 3'b000, 3'b000); check("R5 ena dropped", 8'h08, 3'b000);
        cyc(0, 0, 3'b000, 3'b000); check("R5 still pending", 8'h08, 3'b000);
        cyc(1, 8'h08, 3'b000, 3'b000); check("R5 w1c clears", 8'h00, 3'b000);
    endtask

    task automatic t_merge;
        cyc(0, 0, 3'b001, 3'b001); check("R7 first", 8'h02, 3'b001);
        cyc(0, 0, 3'b001, 3'b001); check("R7 repeat merged", 8'h02, 3'b000);
        cyc(0, 0, 3'b001, 3'b001); check("R7 repeat again", 8'h02, 3'b000);
        cyc(1, 8'h02, 3'b000, 3'b001); check("R7 cleared", 8'h00, 3'b000);
        cyc(0, 0, 3'b001, 3'b001); check("R7 fresh pulse", 8'h02, 3'b001);
        cyc(1, 8'h02, 3'b000, 3'b001); check("R4 tidy", 8'h00, 3'b000);
    endtask

    task automatic t_collision;
        cyc(0, 0, 3'b010, 3'b010); check("R8 pre-set", 8'h04, 3'b010);
        cyc(1, 8'h04, 3'b010, 3'b010); check("R8 set wins no pulse", 8'h04, 3'b000);
        cyc(1, 8'h04, 3'b000, 3'b010); check("R8 clear after", 8'h00, 3'b000);
        cyc(1, 8'h04, 3'b010, 3'b010); check("R8 from clear pulses", 8'h04, 3'b010);
        cyc(1, 8'h04, 3'b000, 3'b010); check("R8 tidy", 8'h00, 3'b000);
    endtask

    task automatic t_independent;
        cyc(0, 0, 3'b101, 3'b111); check("R10 two set", 8'h0A, 3'b101);
        cyc(1, 8'h02, 3'b010, 3'b111); check("R10 clear1 set2", 8'h0C, 3'b010);
        cyc(0, 0, 3'b001, 3'b001); check("R10 others hold", 8'h0E, 3'b001);
        cyc(1, 8'h0E, 3'b000, 3'b000); check("R10 clear all", 8'h00, 3'b000);
    endtask

    initial begin
        t_reset();
        t_set_each();
        t_disabled();
        t_w1c();
        t_enable_drop();
        t_merge();
        t_collision();
        t_independent();
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule